// File: doc/BRIEF.md
# Thread-group admission checker

This block decides whether a compute core can take one more thread group. It keeps running totals of the thread slots, shared-memory bytes and register-file entries in use, and of the number of resident groups. For each candidate group it compares those totals against fixed per-core limits. It also takes a yes/no answer from an external slot allocator, which runs a dry search for a contiguous run of free slots. The accept decision is combinational, so a dispatcher can present a request and read the answer in the same cycle.

When the dispatcher asserts the commit strobe with a group ID and the request is accepted, the block does three things. It adds the group's usage to the totals. It signals the allocator to occupy the slots. It stores the start slot and the charged amounts in a table indexed by the group ID. When the retire strobe names a resident group, the block reports that group's start slot and padded length so the allocator can free them. It then subtracts the stored amounts and clears the table entry. Misuse of either strobe raises an error pulse and changes nothing.

Top module: `tg_admit`

## Requirements
- R1: The thread count is rounded up to a whole number of warps (WARP threads each) before any check, and the rounded value is driven on `alloc_len`. With WARP = 32, a count of 1 gives 32, 32 gives 32, and 33 gives 64.
- R2: `admit` is low when the occupied slots plus the padded thread count exceed SLOTS. An exact fit is accepted.
- R3: `admit` is low when `place_ok` is low, even if the total number of free slots is enough.
- R4: `admit` is low when the occupied shared memory plus `req_smem` exceeds SMEM. An exact fit is accepted.
- R5: The register charge is the padded thread count times `req_regs` rounded up to a multiple of four. `admit` is low when the occupied registers plus this charge exceed REGS.
- R6: `admit` is low while the number of resident groups equals MAXG.
- R7: A commit with `admit` high to a free group ID raises `alloc_take` in the same cycle. The usage is added to the totals at the next clock edge, and the entry records `place_start`.
- R8: A commit while `admit` is low is ignored. `alloc_take` stays low, and `err` is high for the one cycle after.
- R9: A commit to a group ID whose entry is already valid is ignored and raises `err` for one cycle.
- R10: A retire of a resident group raises `free_ack` and drives the stored start slot on `free_start` and the padded length on `free_len` in the same cycle. The usage is subtracted at the next edge, and the entry is freed.
- R11: A retire of a group ID with no valid entry is ignored and raises `err` for one cycle.
- R12: A commit and a retire that target different group IDs in the same cycle both take effect.
- R13: After reset all totals are zero, no entry is valid, `err` is low, and a one-thread request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_threads | input | TW | Thread count of the candidate group |
| req_smem | input | SMW | Shared-memory bytes of the candidate group |
| req_regs | input | RPT_W | Registers per thread of the candidate group |
| alloc_len | output | PW | Warp-padded thread count sent to the slot allocator |
| place_ok | input | 1 | Allocator dry-run result: a contiguous run of free slots exists |
| place_start | input | SW | Start slot found by the allocator |
| admit | output | 1 | Candidate group fits on this core |
| commit | input | 1 | Launch the candidate group |
| commit_gid | input | GW | Group ID for the launch |
| alloc_take | output | 1 | Allocator should occupy the run it found |
| retire | input | 1 | A resident group has finished |
| retire_gid | input | GW | Group ID of the finished group |
| free_ack | output | 1 | Retire was accepted |
| free_start | output | SW | Start slot of the retired group |
| free_len | output | PW | Padded length of the retired group |
| err | output | 1 | One-cycle pulse after a misused strobe |

## Verification
The bench drives each limit to exact equality and then one unit past it. A design that used strict comparison would reject full fits, and one with an off-by-one would admit overflows. Register cases are chosen so that the unrounded product fits but the rounded one does not, and so that a 65-thread group only fails once it is padded. This catches a design that skips either rounding. Duplicate commits, rejected commits and stale retires are each followed by probes that show the totals did not move. A same-cycle commit and retire is then checked through the later free lengths. A design that let one strobe mask the other would leave a stale entry or a wrong total.

// File: rtl/tg_admit_pkg.sv
package tg_admit_pkg;

    // One flag per admission condition; the group fits only when all hold.
    typedef struct packed {
        logic grp_ok;
        logic thr_ok;
        logic place_ok;
        logic smem_ok;
        logic reg_ok;
    } fit_t;

    function automatic logic all_fit(fit_t f);
        return &f;
    endfunction

endpackage

// File: rtl/tg_admit_size.sv
// Warp padding of the thread count and register charge of a request.
module tg_admit_size #(
    parameter int WARP  = 32,
    parameter int TW    = 12,
    parameter int PW    = 13,
    parameter int RPT_W = 8,
    parameter int CW    = 22
) (
    input  logic [TW-1:0]    req_threads,
    input  logic [RPT_W-1:0] req_regs,
    output logic [PW-1:0]    pad,
    output logic [CW-1:0]    cost
);
    localparam int WL = $clog2(WARP);

    logic [PW-1:0]    bumped;
    logic [RPT_W:0]   regs_rnd;

    always_comb begin
        bumped   = PW'(req_threads) + PW'(WARP - 1);
        pad      = (bumped >> WL) << WL;
        regs_rnd = ({1'b0, req_regs} + (RPT_W+1)'(3)) & ~(RPT_W+1)'(3);
        cost     = CW'(pad) * CW'(regs_rnd);
    end

endmodule

// File: rtl/tg_admit_fit.sv
// Capacity comparisons against the per-core limits.
module tg_admit_fit
    import tg_admit_pkg::*;
#(
    parameter int SLOTS = 2048,
    parameter int SMEM  = 98304,
    parameter int REGS  = 65536,
    parameter int MAXG  = 32,
    parameter int TW    = 12,
    parameter int PW    = 13,
    parameter int SMW   = 17,
    parameter int RGW   = 17,
    parameter int CW    = 22,
    parameter int GCW   = 6
) (
    input  logic [TW-1:0]  occ_thr,
    input  logic [PW-1:0]  pad,
    input  logic [SMW-1:0] occ_smem,
    input  logic [SMW-1:0] req_smem,
    input  logic [RGW-1:0] occ_reg,
    input  logic [CW-1:0]  cost,
    input  logic [GCW-1:0] grp,
    input  logic           place_ok,
    output fit_t           fit
);
    always_comb begin
        fit.grp_ok   = int'(grp) < MAXG;
        fit.thr_ok   = int'(occ_thr) + int'(pad) <= SLOTS;
        fit.place_ok = place_ok;
        fit.smem_ok  = int'(occ_smem) + int'(req_smem) <= SMEM;
        fit.reg_ok   = int'(occ_reg) + int'(cost) <= REGS;
    end

endmodule

// File: rtl/tg_admit_table.sv
// Group-ID table: start slot and charged amounts per resident group.
module tg_admit_table #(
    parameter int DEPTH = 32,
    parameter int GW    = 5,
    parameter int SW    = 11,
    parameter int PW    = 13,
    parameter int SMW   = 17,
    parameter int CW    = 22
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           set_en,
    input  logic [GW-1:0]  set_gid,
    input  logic [SW-1:0]  set_start,
    input  logic [PW-1:0]  set_pad,
    input  logic [SMW-1:0] set_smem,
    input  logic [CW-1:0]  set_cost,
    input  logic           clr_en,
    input  logic [GW-1:0]  clr_gid,
    input  logic [GW-1:0]  rd_gid,
    output logic           rd_valid,
    output logic [SW-1:0]  rd_start,
    output logic [PW-1:0]  rd_pad,
    output logic [SMW-1:0] rd_smem,
    output logic [CW-1:0]  rd_cost,
    input  logic [GW-1:0]  chk_gid,
    output logic           chk_free
);
    typedef struct packed {
        logic [SW-1:0]  start;
        logic [PW-1:0]  pad;
        logic [SMW-1:0] smem;
        logic [CW-1:0]  cost;
    } ent_t;

    typedef struct packed {
        logic [DEPTH-1:0]       valid;
        ent_t [DEPTH-1:0]       ent;
    } tab_t;

    tab_t tab_q, tab_d;

    always_comb begin
        tab_d = tab_q;
        if (clr_en) begin
            tab_d.valid[clr_gid] = 1'b0;
        end
        if (set_en) begin
            tab_d.valid[set_gid]     = 1'b1;
            tab_d.ent[set_gid].start = set_start;
            tab_d.ent[set_gid].pad   = set_pad;
            tab_d.ent[set_gid].smem  = set_smem;
            tab_d.ent[set_gid].cost  = set_cost;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tab_q <= '0;
        end else begin
            tab_q <= tab_d;
        end
    end

    always_comb begin
        rd_valid = (int'(rd_gid) < DEPTH) && tab_q.valid[rd_gid];
        rd_start = tab_q.ent[rd_gid].start;
        rd_pad   = tab_q.ent[rd_gid].pad;
        rd_smem  = tab_q.ent[rd_gid].smem;
        rd_cost  = tab_q.ent[rd_gid].cost;
        chk_free = (int'(chk_gid) < DEPTH) && !tab_q.valid[chk_gid];
    end

    // R9: a write only lands on a free entry
    a_r9_set_free: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> !tab_q.valid[set_gid]);

    // R7: a committed entry is valid after the edge
    a_r7_set_entry: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> tab_q.valid[$past(set_gid)]);

    // R10: a retired entry is freed after the edge
    a_r10_clear_entry: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !tab_q.valid[$past(clr_gid)]);

endmodule

// File: rtl/tg_admit.sv
// Thread-group admission checker: capacity totals, accept decision, group table.
module tg_admit
    import tg_admit_pkg::*;
#(
    parameter int WARP  = 32,
    parameter int SLOTS = 2048,
    parameter int SMEM  = 98304,
    parameter int REGS  = 65536,
    parameter int MAXG  = 32,
    parameter int RPT_W = 8,
    localparam int TW  = $clog2(SLOTS + 1),
    localparam int PW  = TW + 1,
    localparam int SW  = $clog2(SLOTS),
    localparam int SMW = $clog2(SMEM + 1),
    localparam int RGW = $clog2(REGS + 1),
    localparam int CW  = PW + RPT_W + 1,
    localparam int GW  = (MAXG > 1) ? $clog2(MAXG) : 1,
    localparam int GCW = $clog2(MAXG + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TW-1:0]    req_threads,
    input  logic [SMW-1:0]   req_smem,
    input  logic [RPT_W-1:0] req_regs,
    output logic [PW-1:0]    alloc_len,
    input  logic             place_ok,
    input  logic [SW-1:0]    place_start,
    output logic             admit,
    input  logic             commit,
    input  logic [GW-1:0]    commit_gid,
    output logic             alloc_take,
    input  logic             retire,
    input  logic [GW-1:0]    retire_gid,
    output logic             free_ack,
    output logic [SW-1:0]    free_start,
    output logic [PW-1:0]    free_len,
    output logic             err
);
    typedef struct packed {
        logic [TW-1:0]  thr;
        logic [SMW-1:0] smem;
        logic [RGW-1:0] regs;
        logic [GCW-1:0] grp;
        logic           err;
    } st_t;

    st_t st_q, st_d;

    logic [PW-1:0]  pad;
    logic [CW-1:0]  cost;
    fit_t           fit;
    logic           chk_free;
    logic           rd_valid;
    logic [SW-1:0]  rd_start;
    logic [PW-1:0]  rd_pad;
    logic [SMW-1:0] rd_smem;
    logic [CW-1:0]  rd_cost;
    logic           take;
    logic           ret_ok;

    tg_admit_size #(
        .WARP(WARP), .TW(TW), .PW(PW), .RPT_W(RPT_W), .CW(CW)
    ) u_size (
        .req_threads(req_threads),
        .req_regs   (req_regs),
        .pad        (pad),
        .cost       (cost)
    );

    tg_admit_fit #(
        .SLOTS(SLOTS), .SMEM(SMEM), .REGS(REGS), .MAXG(MAXG),
        .TW(TW), .PW(PW), .SMW(SMW), .RGW(RGW), .CW(CW), .GCW(GCW)
    ) u_fit (
        .occ_thr (st_q.thr),
        .pad     (pad),
        .occ_smem(st_q.smem),
        .req_smem(req_smem),
        .occ_reg (st_q.regs),
        .cost    (cost),
        .grp     (st_q.grp),
        .place_ok(place_ok),
        .fit     (fit)
    );

    tg_admit_table #(
        .DEPTH(MAXG), .GW(GW), .SW(SW), .PW(PW), .SMW(SMW), .CW(CW)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (take),
        .set_gid  (commit_gid),
        .set_start(place_start),
        .set_pad  (pad),
        .set_smem (req_smem),
        .set_cost (cost),
        .clr_en   (ret_ok),
        .clr_gid  (retire_gid),
        .rd_gid   (retire_gid),
        .rd_valid (rd_valid),
        .rd_start (rd_start),
        .rd_pad   (rd_pad),
        .rd_smem  (rd_smem),
        .rd_cost  (rd_cost),
        .chk_gid  (commit_gid),
        .chk_free (chk_free)
    );

    assign admit      = all_fit(fit);
    assign alloc_len  = pad;
    assign alloc_take = take;
    assign free_ack   = ret_ok;
    assign free_start = rd_start;
    assign free_len   = rd_pad;
    assign err        = st_q.err;

    always_comb begin
        take   = commit & admit & chk_free;
        ret_ok = retire & rd_valid;
        st_d   = st_q;
        if (take) begin
            st_d.thr  = st_d.thr + TW'(pad);
            st_d.smem = st_d.smem + req_smem;
            st_d.regs = st_d.regs + RGW'(cost);
            st_d.grp  = st_d.grp + GCW'(1);
        end
        if (ret_ok) begin
            st_d.thr  = st_d.thr - TW'(rd_pad);
            st_d.smem = st_d.smem - rd_smem;
            st_d.regs = st_d.regs - RGW'(rd_cost);
            st_d.grp  = st_d.grp - GCW'(1);
        end
        st_d.err = (commit & ~take) | (retire & ~rd_valid);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: occupied slots never pass the slot limit
    a_r2_thr_cap: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.thr) <= SLOTS);

    // R6: resident group count never passes the maximum
    a_r6_grp_cap: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.grp) <= MAXG);

    // R7: a lone commit adds exactly the padded length
    a_r7_commit_adds: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !ret_ok) |=> int'(st_q.thr) == int'($past(st_q.thr)) + int'($past(pad)));

    // R8: a commit while rejected raises the error pulse
    a_r8_reject_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !admit) |=> err);

    // R10: a retire never drives a total below zero
    a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        ret_ok |-> (int'(rd_pad) <= int'(st_q.thr)) && (int'(rd_cost) <= int'(st_q.regs))
                   && (int'(rd_smem) <= int'(st_q.smem)));

endmodule

// File: tb/tg_admit_tb.sv
module tg_admit_tb;
    localparam int WARP  = 32;
    localparam int SLOTS = 256;
    localparam int SMEM  = 1000;
    localparam int REGS  = 2048;
    localparam int MAXG  = 4;
    localparam int RPT_W = 8;
    localparam int TW  = $clog2(SLOTS + 1);
    localparam int PW  = TW + 1;
    localparam int SW  = $clog2(SLOTS);
    localparam int SMW = $clog2(SMEM + 1);
    localparam int GW  = $clog2(MAXG);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [TW-1:0]    req_threads = '0;
    logic [SMW-1:0]   req_smem = '0;
    logic [RPT_W-1:0] req_regs = '0;
    logic [PW-1:0]    alloc_len;
    logic             place_ok = 1'b1;
    logic [SW-1:0]    place_start = '0;
    logic             admit;
    logic             commit = 1'b0;
    logic [GW-1:0]    commit_gid = '0;
    logic             alloc_take;
    logic             retire = 1'b0;
    logic [GW-1:0]    retire_gid = '0;
    logic             free_ack;
    logic [SW-1:0]    free_start;
    logic [PW-1:0]    free_len;
    logic             err;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    tg_admit #(
        .WARP(WARP), .SLOTS(SLOTS), .SMEM(SMEM), .REGS(REGS), .MAXG(MAXG), .RPT_W(RPT_W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_threads(req_threads), .req_smem(req_smem), .req_regs(req_regs),
        .alloc_len(alloc_len), .place_ok(place_ok), .place_start(place_start),
        .admit(admit), .commit(commit), .commit_gid(commit_gid), .alloc_take(alloc_take),
        .retire(retire), .retire_gid(retire_gid), .free_ack(free_ack),
        .free_start(free_start), .free_len(free_len), .err(err)
    );

    task automatic chk(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic set_req(int t, int s, int r, bit f);
        req_threads = t[TW-1:0];
        req_smem    = s[SMW-1:0];
        req_regs    = r[RPT_W-1:0];
        place_ok    = f;
    endtask

    task automatic probe(int t, int s, int r, bit f, int exp, string tag);
        @(negedge clk);
        set_req(t, s, r, f);
        #1 chk(tag, int'(admit), exp);
    endtask

    task automatic do_commit(int gid, int t, int s, int r, int start,
                             int exp_take, int exp_err, string tag);
        @(negedge clk);
        set_req(t, s, r, 1'b1);
        place_start = start[SW-1:0];
        commit_gid  = gid[GW-1:0];
        commit      = 1'b1;
        #1 chk({tag, " take"}, int'(alloc_take), exp_take);
        @(negedge clk);
        commit = 1'b0;
        chk({tag, " err"}, int'(err), exp_err);
    endtask

    task automatic do_retire(int gid, int exp_ack, int exp_start, int exp_len,
                             int exp_err, string tag);
        @(negedge clk);
        retire_gid = gid[GW-1:0];
        retire     = 1'b1;
        #1 chk({tag, " ack"}, int'(free_ack), exp_ack);
        if (exp_ack != 0) begin
            chk({tag, " start"}, int'(free_start), exp_start);
            chk({tag, " len"}, int'(free_len), exp_len);
        end
        @(negedge clk);
        retire = 1'b0;
        chk({tag, " err"}, int'(err), exp_err);
    endtask

    task automatic t_reset();
        probe(1, 0, 1, 1'b1, 1, "R13 admit after reset");
        chk("R13 err after reset", int'(err), 0);
        chk("R13 no take", int'(alloc_take), 0);
        chk("R13 no ack", int'(free_ack), 0);
    endtask

    task automatic t_padding();
        probe(1, 0, 0, 1'b1, 1, "R1 t1");
        chk("R1 pad of 1", int'(alloc_len), 32);
        probe(32, 0, 0, 1'b1, 1, "R1 t32");
        chk("R1 pad of 32", int'(alloc_len), 32);
        probe(33, 0, 0, 1'b1, 1, "R1 t33");
        chk("R1 pad of 33", int'(alloc_len), 64);
    endtask

    task automatic t_limits();
        probe(256, 0, 0, 1'b1, 1, "R2 exact slot fit");
        probe(257, 0, 0, 1'b1, 0, "R2 slot overflow");
        probe(32, 0, 0, 1'b0, 0, "R3 dry run fails");
        probe(1, 1000, 0, 1'b1, 1, "R4 exact smem fit");
        probe(1, 1001, 0, 1'b1, 0, "R4 smem overflow");
        probe(96, 0, 21, 1'b1, 0, "R5 rounded regs overflow");
        probe(96, 0, 20, 1'b1, 1, "R5 regs fit");
        probe(65, 0, 21, 1'b1, 0, "R5 padded threads overflow");
        probe(65, 0, 20, 1'b1, 1, "R5 padded fit");
        probe(64, 0, 32, 1'b1, 1, "R5 exact reg fit");
    endtask

    task automatic t_commit();
        do_commit(0, 40, 600, 8, 10, 1, 0, "R7 commit g0");
        probe(192, 0, 0, 1'b1, 1, "R7 slots left exact");
        probe(193, 0, 0, 1'b1, 0, "R7 slots left over");
        probe(1, 400, 0, 1'b1, 1, "R7 smem left exact");
        probe(1, 401, 0, 1'b1, 0, "R7 smem left over");
        probe(64, 0, 24, 1'b1, 1, "R7 regs left exact");
        probe(64, 0, 25, 1'b1, 0, "R7 regs left over");
    endtask

    task automatic t_bad_commits();
        do_commit(0, 1, 0, 0, 3, 0, 1, "R9 duplicate g0");
        probe(192, 0, 0, 1'b1, 1, "R9 totals unchanged");
        probe(193, 0, 0, 1'b1, 0, "R9 totals unchanged hi");
        do_commit(1, 200, 0, 0, 5, 0, 1, "R8 rejected commit");
        probe(192, 0, 0, 1'b1, 1, "R8 totals unchanged");
        do_retire(1, 0, 0, 0, 1, "R8 no entry for g1");
    endtask

    task automatic t_retire();
        do_retire(0, 1, 10, 64, 0, "R10 retire g0");
        probe(256, 0, 0, 1'b1, 1, "R10 slots freed");
        probe(1, 1000, 0, 1'b1, 1, "R10 smem freed");
        probe(64, 0, 32, 1'b1, 1, "R10 regs freed");
        do_retire(0, 0, 0, 0, 1, "R11 stale retire g0");
        probe(256, 0, 0, 1'b1, 1, "R11 totals unchanged");
    endtask

    task automatic t_groups();
        for (int g = 0; g < 3; g++) begin
            do_commit(g, 1, 0, 1, g * 32, 1, 0, "R6 fill");
        end
        probe(1, 0, 0, 1'b1, 1, "R6 below max");
        do_commit(3, 1, 0, 1, 96, 1, 0, "R6 fill last");
        probe(1, 0, 0, 1'b1, 0, "R6 at max");
    endtask

    task automatic t_overlap();
        do_retire(3, 1, 96, 32, 0, "R12 retire g3");
        @(negedge clk);
        set_req(64, 0, 0, 1'b1);
        place_start = 8'd200;
        commit_gid  = 2'd3;
        commit      = 1'b1;
        retire_gid  = 2'd0;
        retire      = 1'b1;
        #1;
        chk("R12 take", int'(alloc_take), 1);
        chk("R12 ack", int'(free_ack), 1);
        chk("R12 start g0", int'(free_start), 0);
        chk("R12 len g0", int'(free_len), 32);
        @(negedge clk);
        commit = 1'b0;
        retire = 1'b0;
        chk("R12 no err", int'(err), 0);
        probe(128, 0, 0, 1'b1, 1, "R12 slots exact");
        probe(129, 0, 0, 1'b1, 0, "R12 slots over");
        do_retire(3, 1, 200, 64, 0, "R12 g3 recorded");
        do_retire(0, 0, 0, 0, 1, "R12 g0 freed");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_padding();
        t_limits();
        t_commit();
        t_bad_commits();
        t_retire();
        t_groups();
        t_overlap();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule